// File: doc/BRIEF.md
# Strided Vector Operation Sequencer

The block runs one vector arithmetic instruction at a time. It decodes the instruction word and, for the arithmetic entry, a following sub-opcode word. It then walks operand arrays in a word-addressed memory. Each array has its own base address and its own signed element stride. For every element it reads the operands, passes the operand pair to an external arithmetic unit through a request/acknowledge handshake, and writes the returned result to the destination array. The floating-point unit, the fetch of the operand list and the memory itself are outside the block. The surrounding processor supplies the bases, strides and element count as plain inputs together with a one-cycle `start`.

Two forms are supported. In the vector-vector form, result element i is A[i] op B[i]. In the scalar-vector form, one scalar is read once from the A base and each result is scalar op B[i]. In single precision an element occupies 2 words, and in double precision 4 words, so the strides are scaled to match. A self-test entry returns fixed identification values for the X and S registers and asks for one extra return word. Every other entry is reported as illegal.

Top module: `strided_vec_seq`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `done`, `illegal`, `mem_req` and `ar_req` are low.
- R2: Vector-vector form (sub-opcode bit 8 clear, entry `instr[3:0]`=0): for element i = 0..n-1, A is read at `src_a_base + i*src_a_stride*k` and B at `src_b_base + i*src_b_stride*k`. The result is written at `dst_base + i*dst_stride*k`, where k = 2 when `instr[11]` is 0 and k = 4 when it is 1. `mem_dbl` and `ar_dbl` equal `instr[11]`.
- R3: Scalar-vector form (sub-opcode bit 8 set): the scalar is read once at `src_a_base` before the first element. Each result is scalar op B[i], with `ar_a` holding the scalar and `ar_b` holding B[i].
- R4: Sub-opcode bits 5:4 select `ar_op`: 0 add, 1 subtract (a-b), 2 multiply, 3 divide (a/b). `ar_op`, `ar_a` and `ar_b` hold steady while `ar_req` waits for `ar_ack`.
- R5: When sub-opcode bit 15 is 1, the value on `areg` is decoded as the sub-opcode in place of `subop`.
- R6: Strides are two's-complement 16-bit values, so a negative stride walks toward lower addresses.
- R7: Every address is computed modulo 2^15.
- R8: A signed element count of zero or less gives `done` in the cycle after `start`, with no memory request and no arithmetic request.
- R9: Entry 15 is the self-test. In the cycle after `start`, `done`, `xreg_ld`, `sreg_ld` and `ret_skip` pulse together, with `xreg_val`=3 and `sreg_val`=0102077 octal. No memory access takes place.
- R10: Entries 1 to 14 pulse `illegal` together with `done` in the cycle after `start`, with no memory access and no register load.
- R11: `done` is a single-cycle pulse. For a vector run it is high in the cycle right after the last write is accepted.
- R12: Memory accesses are issued in order: the scalar read (scalar-vector form only), then for each element the A read (vector-vector form only), the B read and the result write. Address and write enable hold steady while `mem_req` waits for `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction; sampled when not busy |
| instr | input | 16 | Instruction word: bit 11 precision, bits 3:0 entry |
| subop | input | 16 | Arithmetic sub-opcode word |
| areg | input | 16 | A register value, used as the sub-opcode on re-entry |
| src_a_base | input | 15 | Base word address of A or of the scalar |
| src_a_stride | input | 16 | Signed element stride of A |
| src_b_base | input | 15 | Base word address of B |
| src_b_stride | input | 16 | Signed element stride of B |
| dst_base | input | 15 | Base word address of the result array |
| dst_stride | input | 16 | Signed element stride of the result array |
| elem_count | input | 16 | Signed element count |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Unimplemented-entry pulse, given with done |
| xreg_ld | output | 1 | Load X register with xreg_val |
| xreg_val | output | 16 | Self-test revision value |
| sreg_ld | output | 1 | Load S register with sreg_val |
| sreg_val | output | 16 | Self-test pass code |
| ret_skip | output | 1 | Return skips one extra word |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_dbl | output | 1 | Element is 4 words (1) or 2 words (0) |
| mem_addr | output | 15 | Element word address |
| mem_wdata | output | 64 | Write element data |
| mem_ack | input | 1 | Memory accepts the request; read data valid |
| mem_rdata | input | 64 | Read element data |
| ar_req | output | 1 | Arithmetic request, held until acknowledged |
| ar_op | output | 2 | Arithmetic operation code |
| ar_dbl | output | 1 | Double-precision operands |
| ar_a | output | 64 | First operand |
| ar_b | output | 64 | Second operand |
| ar_ack | input | 1 | Arithmetic result valid |
| ar_res | input | 64 | Arithmetic result |

## Verification
A wrong pointer or stride register appears at `mem_addr` on the very first access that uses it, because every accepted access is compared in order against the expected address, direction and write data. A mis-decoded form or operation appears as an extra or missing read, or as a wrong value at the first write. A stale element counter appears as a `done` that comes out of step with the final accepted write, or as an access left over or missing at the end. Immediate completions (count of zero or less, self-test, illegal entry) are checked one cycle after `start`, together with zero traffic on both handshakes.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  localparam int NUM_PTR = 3;
  localparam int PTR_A   = 0;
  localparam int PTR_B   = 1;
  localparam int PTR_D   = 2;

  localparam logic [3:0]  ENTRY_ARITH = 4'd0;
  localparam logic [3:0]  ENTRY_TEST  = 4'd15;
  localparam logic [15:0] TEST_REV    = 16'd3;
  localparam logic [15:0] TEST_CODE   = 16'o102077;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } arith_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_S,
    ST_RD_A,
    ST_RD_B,
    ST_CALC,
    ST_WR
  } seq_state_e;

  typedef struct packed {
    logic      dbl;
    logic      is_arith;
    logic      is_test;
    logic      is_bad;
    logic      scalar;
    arith_op_e op;
  } dec_t;

endpackage

// File: rtl/vseq_decode.sv
module vseq_decode
  import vseq_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] subop,
  input  logic [WORD_W-1:0] areg,
  output dec_t              dec
);

  localparam int DBL_BIT     = 11;
  localparam int SV_BIT      = 8;
  localparam int REENTRY_BIT = 15;
  localparam int OP_LSB      = 4;
  localparam int ENTRY_W     = 4;

  logic [WORD_W-1:0]  eff;
  logic [ENTRY_W-1:0] entry;
  logic               unused_dec;

  always_comb begin
    eff          = subop[REENTRY_BIT] ? areg : subop;
    entry        = instr[ENTRY_W-1:0];
    dec.dbl      = instr[DBL_BIT];
    dec.is_arith = (entry == ENTRY_ARITH);
    dec.is_test  = (entry == ENTRY_TEST);
    dec.is_bad   = !dec.is_arith && !dec.is_test;
    dec.scalar   = eff[SV_BIT];
    dec.op       = arith_op_e'(eff[OP_LSB +: 2]);
  end

  assign unused_dec = ^{instr[WORD_W-1:DBL_BIT+1], instr[DBL_BIT-1:ENTRY_W],
                        eff[WORD_W-1:SV_BIT+1], eff[SV_BIT-1:OP_LSB+2],
                        eff[OP_LSB-1:0]};

endmodule

// File: rtl/vseq_agu.sv
module vseq_agu #(
  parameter int ADDR_W = 15,
  parameter int WORD_W = 16,
  parameter int NPTR   = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load,
  input  logic                          step,
  input  logic                          dbl,
  input  logic [NPTR-1:0][ADDR_W-1:0]   base,
  input  logic [NPTR-1:0][WORD_W-1:0]   stride,
  output logic [NPTR-1:0][ADDR_W-1:0]   ptr
);

  localparam int SCL_W = WORD_W + 2;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic [SCL_W-1:0]  wide;
    logic [ADDR_W-1:0] inc_q;
    logic              unused_hi;

    // element stride in words: x2 single, x4 double; only the low bits matter
    always_comb begin
      wide = dbl ? {stride[g], 2'b00} : {1'b0, stride[g], 1'b0};
    end
    assign unused_hi = ^wide[SCL_W-1:ADDR_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        ptr[g] <= '0;
        inc_q  <= '0;
      end else if (load) begin
        ptr[g] <= base[g];
        inc_q  <= wide[ADDR_W-1:0];
      end else if (step) begin
        ptr[g] <= ptr[g] + inc_q;
      end
    end

    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (!load && !step) |=> $stable(ptr[g]));
  end

endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int WORD_W = 16,
  parameter int DATA_W = 64
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start,
  input  dec_t                             dec,
  input  logic signed [WORD_W-1:0]         count,
  input  logic [NUM_PTR-1:0][ADDR_W-1:0]   ptr,
  output logic                             agu_load,
  output logic                             agu_step,
  output logic                             dbl_q,
  output logic                             busy,
  output logic                             done,
  output logic                             illegal,
  output logic                             xreg_ld,
  output logic                             sreg_ld,
  output logic                             ret_skip,
  output logic                             mem_req,
  output logic                             mem_we,
  output logic [ADDR_W-1:0]                mem_addr,
  output logic [DATA_W-1:0]                mem_wdata,
  input  logic                             mem_ack,
  input  logic [DATA_W-1:0]                mem_rdata,
  output logic                             ar_req,
  output arith_op_e                        ar_op,
  output logic [DATA_W-1:0]                ar_a,
  output logic [DATA_W-1:0]                ar_b,
  input  logic                             ar_ack,
  input  logic [DATA_W-1:0]                ar_res
);

  seq_state_e               state;
  logic                     scalar_q;
  logic signed [WORD_W-1:0] rem_q;
  logic [DATA_W-1:0]        opa_q, opb_q, res_q;

  assign agu_load  = start && (state == ST_IDLE);
  assign agu_step  = (state == ST_WR) && mem_ack;
  assign busy      = (state != ST_IDLE);
  assign mem_req   = (state == ST_RD_S) || (state == ST_RD_A) ||
                     (state == ST_RD_B) || (state == ST_WR);
  assign mem_we    = (state == ST_WR);
  assign ar_req    = (state == ST_CALC);
  assign mem_wdata = res_q;
  assign ar_a      = opa_q;
  assign ar_b      = opb_q;

  always_comb begin
    case (state)
      ST_RD_S, ST_RD_A: mem_addr = ptr[PTR_A];
      ST_RD_B:          mem_addr = ptr[PTR_B];
      ST_WR:            mem_addr = ptr[PTR_D];
      default:          mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      dbl_q    <= 1'b0;
      scalar_q <= 1'b0;
      ar_op    <= OP_ADD;
      rem_q    <= '0;
      opa_q    <= '0;
      opb_q    <= '0;
      res_q    <= '0;
      done     <= 1'b0;
      illegal  <= 1'b0;
      xreg_ld  <= 1'b0;
      sreg_ld  <= 1'b0;
      ret_skip <= 1'b0;
    end else begin
      done     <= 1'b0;
      illegal  <= 1'b0;
      xreg_ld  <= 1'b0;
      sreg_ld  <= 1'b0;
      ret_skip <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          dbl_q    <= dec.dbl;
          scalar_q <= dec.scalar;
          ar_op    <= dec.op;
          rem_q    <= count;
          if (dec.is_bad) begin
            done    <= 1'b1;
            illegal <= 1'b1;
          end else if (dec.is_test) begin
            done     <= 1'b1;
            xreg_ld  <= 1'b1;
            sreg_ld  <= 1'b1;
            ret_skip <= 1'b1;
          end else if (count <= 0) begin
            done <= 1'b1;
          end else begin
            state <= dec.scalar ? ST_RD_S : ST_RD_A;
          end
        end
        ST_RD_S, ST_RD_A: if (mem_ack) begin
          opa_q <= mem_rdata;
          state <= ST_RD_B;
        end
        ST_RD_B: if (mem_ack) begin
          opb_q <= mem_rdata;
          state <= ST_CALC;
        end
        ST_CALC: if (ar_ack) begin
          res_q <= ar_res;
          state <= ST_WR;
        end
        ST_WR: if (mem_ack) begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == 1) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state <= scalar_q ? ST_RD_B : ST_RD_A;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_ar_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (ar_req && !ar_ack) |=> (ar_req && $stable(ar_op) && $stable(ar_a) && $stable(ar_b)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!mem_req && !ar_req));

  assert_illegal_with_done_R10: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (done && !xreg_ld && !sreg_ld));

  assert_selftest_pulses_R9: assert property (@(posedge clk) disable iff (rst)
    xreg_ld |-> (done && sreg_ld && ret_skip && !illegal));

endmodule

// File: rtl/strided_vec_seq.sv
module strided_vec_seq
  import vseq_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int WORD_W = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] subop,
  input  logic [WORD_W-1:0] areg,
  input  logic [ADDR_W-1:0] src_a_base,
  input  logic [WORD_W-1:0] src_a_stride,
  input  logic [ADDR_W-1:0] src_b_base,
  input  logic [WORD_W-1:0] src_b_stride,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [WORD_W-1:0] dst_stride,
  input  logic [WORD_W-1:0] elem_count,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic              xreg_ld,
  output logic [WORD_W-1:0] xreg_val,
  output logic              sreg_ld,
  output logic [WORD_W-1:0] sreg_val,
  output logic              ret_skip,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_dbl,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ar_req,
  output logic [1:0]        ar_op,
  output logic              ar_dbl,
  output logic [DATA_W-1:0] ar_a,
  output logic [DATA_W-1:0] ar_b,
  input  logic              ar_ack,
  input  logic [DATA_W-1:0] ar_res
);

  dec_t                           dec;
  logic [NUM_PTR-1:0][ADDR_W-1:0] bases;
  logic [NUM_PTR-1:0][WORD_W-1:0] strides;
  logic [NUM_PTR-1:0][ADDR_W-1:0] ptr;
  logic                           agu_load, agu_step, dbl_q;
  arith_op_e                      op_e;

  assign bases[PTR_A]   = src_a_base;
  assign bases[PTR_B]   = src_b_base;
  assign bases[PTR_D]   = dst_base;
  assign strides[PTR_A] = src_a_stride;
  assign strides[PTR_B] = src_b_stride;
  assign strides[PTR_D] = dst_stride;

  assign xreg_val = WORD_W'(TEST_REV);
  assign sreg_val = WORD_W'(TEST_CODE);
  assign mem_dbl  = dbl_q;
  assign ar_dbl   = dbl_q;
  assign ar_op    = op_e;

  vseq_decode #(.WORD_W(WORD_W)) u_decode (
    .instr (instr),
    .subop (subop),
    .areg  (areg),
    .dec   (dec)
  );

  vseq_agu #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .NPTR(NUM_PTR)) u_agu (
    .clk    (clk),
    .rst    (rst),
    .load   (agu_load),
    .step   (agu_step),
    .dbl    (dec.dbl),
    .base   (bases),
    .stride (strides),
    .ptr    (ptr)
  );

  vseq_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .dec       (dec),
    .count     (elem_count),
    .ptr       (ptr),
    .agu_load  (agu_load),
    .agu_step  (agu_step),
    .dbl_q     (dbl_q),
    .busy      (busy),
    .done      (done),
    .illegal   (illegal),
    .xreg_ld   (xreg_ld),
    .sreg_ld   (sreg_ld),
    .ret_skip  (ret_skip),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .ar_req    (ar_req),
    .ar_op     (op_e),
    .ar_a      (ar_a),
    .ar_b      (ar_b),
    .ar_ack    (ar_ack),
    .ar_res    (ar_res)
  );

endmodule

// File: tb/strided_vec_seq_bench.sv
`timescale 1ns/1ps
module strided_vec_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] instr = '0, subop = '0, areg = '0;
  logic [14:0] src_a_base = '0, src_b_base = '0, dst_base = '0;
  logic [15:0] src_a_stride = '0, src_b_stride = '0, dst_stride = '0, elem_count = '0;
  logic        busy, done, illegal, xreg_ld, sreg_ld, ret_skip;
  logic [15:0] xreg_val, sreg_val;
  logic        mem_req, mem_we, mem_dbl, mem_ack;
  logic [14:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic        ar_req, ar_dbl, ar_ack;
  logic [1:0]  ar_op;
  logic [63:0] ar_a, ar_b, ar_res;

  always #10 clk = ~clk;

  strided_vec_seq u_strided_vec_seq (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .subop(subop), .areg(areg),
    .src_a_base(src_a_base), .src_a_stride(src_a_stride),
    .src_b_base(src_b_base), .src_b_stride(src_b_stride),
    .dst_base(dst_base), .dst_stride(dst_stride), .elem_count(elem_count),
    .busy(busy), .done(done), .illegal(illegal),
    .xreg_ld(xreg_ld), .xreg_val(xreg_val), .sreg_ld(sreg_ld), .sreg_val(sreg_val),
    .ret_skip(ret_skip), .mem_req(mem_req), .mem_we(mem_we), .mem_dbl(mem_dbl),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ar_req(ar_req), .ar_op(ar_op), .ar_dbl(ar_dbl), .ar_a(ar_a), .ar_b(ar_b),
    .ar_ack(ar_ack), .ar_res(ar_res)
  );

  int checks = 0;
  int fails = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // stub arithmetic: integer ops, single precision uses low 32 bits
  function automatic logic [63:0] calc(input logic [1:0] op, input logic [63:0] a,
                                       input logic [63:0] b, input logic dbl);
    logic [63:0] x, y, r;
    x = dbl ? a : {32'b0, a[31:0]};
    y = dbl ? b : {32'b0, b[31:0]};
    case (op)
      2'd0: r = x + y;
      2'd1: r = x - y;
      2'd2: r = x * y;
      default: r = (y == 0) ? 64'd0 : x / y;
    endcase
    return dbl ? r : {32'b0, r[31:0]};
  endfunction

  // memory model, one element per starting word address
  logic [63:0] mem [0:1023];
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      for (int i = 0; i < 1024; i++)
        mem[i] <= {24'(i), 8'h00, 32'(i * 3 + 7)};
    end else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[9:0]];
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  always @(posedge clk) begin
    if (rst) ar_ack <= 1'b0;
    else if (ar_req && !ar_ack) begin
      ar_ack <= 1'b1;
      ar_res <= calc(ar_op, ar_a, ar_b, ar_dbl);
    end else ar_ack <= 1'b0;
  end

  // scoreboard
  typedef struct {
    bit          we;
    logic [14:0] addr;
    logic [63:0] data;
  } acc_t;
  acc_t  exp_q[$];
  string cur_tag = "R2";
  bit    vec_mode = 0;
  bit    wr_last_prev = 0;
  int    traffic = 0;
  int    ar_traffic = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (vec_mode && (done || wr_last_prev))
        chk("R11 done right after last write", {63'b0, done}, {63'b0, wr_last_prev});
      wr_last_prev = 0;
      if (mem_req && mem_ack) begin
        traffic++;
        if (exp_q.size() == 0) begin
          chk("R12 unexpected access", {49'b0, mem_addr}, 64'hFFFF);
        end else begin
          acc_t e;
          e = exp_q.pop_front();
          chk("R12 access direction", {63'b0, mem_we}, {63'b0, e.we});
          chk({cur_tag, " access address"}, {49'b0, mem_addr}, {49'b0, e.addr});
          if (e.we) begin
            chk({cur_tag, " write data"}, mem_wdata, e.data);
            if (exp_q.size() == 0) wr_last_prev = 1;
          end
        end
      end
      if (ar_req && ar_ack) ar_traffic++;
    end
  end

  function automatic logic [14:0] eaddr(input logic [14:0] base, input logic [15:0] stride,
                                        input int i, input int k);
    int s;
    s = int'($signed(stride));
    return 15'(int'(base) + i * s * k);
  endfunction

  int          lat;
  logic [7:0]  pulses;

  // drives one instruction, queues expected accesses, waits for done
  task automatic run_op(input logic [15:0] ins, input logic [15:0] sub, input logic [15:0] a_reg,
                        input logic [14:0] ba, input logic [15:0] sa,
                        input logic [14:0] bb, input logic [15:0] sb,
                        input logic [14:0] bd, input logic [15:0] sd,
                        input int n, input string tag);
    logic [15:0] eff;
    logic        dbl, scl;
    logic [1:0]  op;
    logic [63:0] sv, av, bv;
    int          k;
    eff = sub[15] ? a_reg : sub;
    dbl = ins[11];
    k   = dbl ? 4 : 2;
    scl = eff[8];
    op  = eff[5:4];
    cur_tag = tag;
    if (ins[3:0] == 4'd0 && n > 0) begin
      sv = mem[ba[9:0]];
      if (scl) exp_q.push_back('{0, ba, 64'd0});
      for (int i = 0; i < n; i++) begin
        logic [14:0] pa, pb, pd;
        pa = eaddr(ba, sa, i, k);
        pb = eaddr(bb, sb, i, k);
        pd = eaddr(bd, sd, i, k);
        av = scl ? sv : mem[pa[9:0]];
        bv = mem[pb[9:0]];
        if (!scl) exp_q.push_back('{0, pa, 64'd0});
        exp_q.push_back('{0, pb, 64'd0});
        exp_q.push_back('{1, pd, calc(op, av, bv, dbl)});
      end
      vec_mode = 1;
    end
    @(negedge clk);
    instr = ins; subop = sub; areg = a_reg;
    src_a_base = ba; src_a_stride = sa;
    src_b_base = bb; src_b_stride = sb;
    dst_base = bd; dst_stride = sd;
    elem_count = 16'(n);
    start = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end while (!done && lat < 3000);
    pulses = {done, illegal, xreg_ld, sreg_ld, ret_skip, busy, 2'b00};
    vec_mode = 0;
    chk({tag, " done reached"}, {63'b0, done}, 64'd1);
    chk({tag, " scoreboard drained"}, 64'(exp_q.size()), 64'd0);
    exp_q.delete();
    @(negedge clk);
    chk("R11 done lasts one cycle", {63'b0, done}, 64'd0);
  endtask

  initial begin
    int t0, a0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {63'b0, busy}, 64'd0);
    chk("R1 done in reset", {63'b0, done}, 64'd0);
    chk("R1 mem_req in reset", {63'b0, mem_req}, 64'd0);
    chk("R1 ar_req in reset", {63'b0, ar_req}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", {61'b0, busy, mem_req, illegal}, 64'd0);

    // R2 R4: vector-vector add, single precision, unit strides
    run_op(16'o101460, 16'o000000, 16'h0, 15'h100, 16'd1, 15'h180, 16'd1, 15'h200, 16'd1, 4, "R2");
    chk("R2 busy low at done", {63'b0, pulses[2]}, 64'd0);
    // R6 R2: vector-vector subtract, double precision, negative B stride
    run_op(16'o105460, 16'o000022, 16'h0, 15'h040, 16'd2, 15'h0C0, 16'hFFFF, 15'h240, 16'd1, 3, "R6");
    // R3 R4: scalar-vector multiply, single, negative dest stride
    run_op(16'o101460, 16'o000440, 16'h0, 15'h010, 16'd9, 15'h280, 16'd3, 15'h2C0, 16'hFFFE, 3, "R3");
    // R5: re-entry, A register selects vector-vector divide
    run_op(16'o101460, 16'h8000, 16'o000060, 15'h300, 16'd1, 15'h340, 16'd1, 15'h380, 16'd1, 2, "R5");
    // R7: A pointer wraps from the top of the 15-bit space to zero
    run_op(16'o101460, 16'o000000, 16'h0, 15'h7FFC, 16'd1, 15'h3C0, 16'd1, 15'h3E0, 16'd1, 3, "R7");

    // R8: zero and negative counts
    t0 = traffic; a0 = ar_traffic;
    run_op(16'o101460, 16'o000000, 16'h0, 15'h100, 16'd1, 15'h180, 16'd1, 15'h200, 16'd1, 0, "R8");
    chk("R8 zero count latency", 64'(lat), 64'd1);
    run_op(16'o105460, 16'o000440, 16'h0, 15'h100, 16'd1, 15'h180, 16'd1, 15'h200, 16'd1, -5, "R8");
    chk("R8 negative count latency", 64'(lat), 64'd1);
    chk("R8 no memory traffic", 64'(traffic - t0), 64'd0);
    chk("R8 no arithmetic traffic", 64'(ar_traffic - a0), 64'd0);

    // R9: self-test entry
    t0 = traffic;
    run_op(16'o105477, 16'o000000, 16'h0, 15'h100, 16'd1, 15'h180, 16'd1, 15'h200, 16'd1, 4, "R9");
    chk("R9 latency", 64'(lat), 64'd1);
    chk("R9 pulses {illegal,xld,sld,skip}", {60'b0, pulses[6:3]}, 64'b0111);
    chk("R9 X value", {48'b0, xreg_val}, 64'd3);
    chk("R9 S value", {48'b0, sreg_val}, 64'o102077);
    chk("R9 no memory traffic", 64'(traffic - t0), 64'd0);

    // R10: unimplemented entry 5
    t0 = traffic;
    run_op(16'o101465, 16'o000000, 16'h0, 15'h100, 16'd1, 15'h180, 16'd1, 15'h200, 16'd1, 4, "R10");
    chk("R10 latency", 64'(lat), 64'd1);
    chk("R10 pulses {illegal,xld,sld,skip}", {60'b0, pulses[6:3]}, 64'b1000);
    chk("R10 no memory traffic", 64'(traffic - t0), 64'd0);

    // R2 R12: memory is intact after the rejected run, double add with mixed strides
    run_op(16'o105460, 16'o000002, 16'h0, 15'h100, 16'd1, 15'h180, 16'd2, 15'h200, 16'd1, 2, "R12");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule